// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block produces the chip selects and the read/write strobes for a 16-bit processor that puts out a 24-bit banked address. The processor drives the upper address byte (the bank) on the shared data bus while the clock is low. The decoder captures that byte in a latch that is open during the low phase and holds its value through the high phase. The latched bank is also an output, so the memories can use it as their upper address lines.

The decoder builds a full address from the latched bank and the 16-bit address. It compares that address against two windows: a ROM window and an I/O window. ROM is selected only on reads. I/O is selected on both reads and writes. RAM is selected whenever neither of the other two is, so a write into the ROM window lands in RAM. The write and output-enable strobes are gated by the clock high phase. All outputs are active-low and combinational.

Top module: `banked_mem_decoder`

## Requirements
- R1: While `clk` is low, `bank_q` follows `data_in`. While `clk` is high, `bank_q` holds the value it had at the rising edge, even if `data_in` changes.
- R2: When `rw` is 1 (read) and the 19-bit address {bank_q[2:0], addr_in} is in 0x00FF00..0x01FFFF inclusive, `rom_cs_n` is 0.
- R3: When `rw` is 0 (write), `rom_cs_n` is 1. A write whose address is in the ROM window drives `ram_cs_n` to 0.
- R4: For either value of `rw`, `io_cs_n` is 0 exactly when the 19-bit address is in 0x020000..0x0200FF inclusive.
- R5: `ram_cs_n` is 0 exactly when `rom_cs_n` and `io_cs_n` are both 1. This covers every address up to 0x07FFFF that no other window claims.
- R6: Exactly one of `ram_cs_n`, `rom_cs_n` and `io_cs_n` is 0 at all times.
- R7: `we_n` is 0 only while `clk` is 1 and `rw` is 0. Otherwise it is 1.
- R8: `oe_n` is 0 only while `clk` is 1 and `rw` is 1. Otherwise it is 1.
- R9: Bank bits 3 to 7 have no effect on any chip select, so the map repeats every 512 KiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor phase clock. Low is the bank phase, high is the data phase. |
| rw | input | 1 | 1 = read, 0 = write |
| addr_in | input | 16 | Low 16 address bits |
| data_in | input | 8 | Shared data bus, which carries the bank while `clk` is low |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | 1 | I/O select, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output-enable strobe, active low |
| bank_q | output | 8 | Latched bank byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit bank and 19 decoded bits. Both windows start and end on 256-byte page boundaries. For that reason, driving the first and the last byte of every page in the 512 KiB space, for both reads and writes, reaches every window edge and every region. A second sweep sets bank bits 3 to 7 to non-zero values at the pages next to each boundary, which shows that the map aliases. Each access also changes the data bus during the high phase, which exercises the latch hold.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  // Window bounds on the folded (decoded) address
  localparam logic [23:0] ROM_LO_DEF = 24'h00FF00;
  localparam logic [23:0] ROM_HI_DEF = 24'h01FFFF;
  localparam logic [23:0] IO_LO_DEF  = 24'h020000;
  localparam logic [23:0] IO_HI_DEF  = 24'h0200FF;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_ROM = 2'd1,
    TGT_IO  = 2'd2
  } target_e;

  // Keep only the low used_bits of a 24-bit address
  function automatic logic [23:0] fold_addr(input logic [23:0] a, input int unsigned used_bits);
    logic [23:0] mask;
    mask = '0;
    for (int i = 0; i < 24; i++) begin
      if (i < used_bits) mask[i] = 1'b1;
    end
    return a & mask;
  endfunction

  function automatic logic in_range(input logic [23:0] a, input logic [23:0] lo,
                                    input logic [23:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/bmd_bank_latch.sv
module bmd_bank_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // One transparent-low latch for each bank bit
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic bit_q;
    always_latch begin
      if (!clk) bit_q = d[g];
    end
    assign q[g] = bit_q;
  end
endmodule

// File: rtl/bmd_window.sv
module bmd_window #(
  parameter int unsigned FULL_W = 24,
  parameter int unsigned USED_W = 19,
  parameter logic [23:0] LO     = 24'h0,
  parameter logic [23:0] HI     = 24'h0
) (
  input  logic [FULL_W-1:0] full_addr,
  output logic              hit
);
  import bmd_pkg::*;
  logic [23:0] wide_addr;
  logic [23:0] folded;

  always_comb begin
    wide_addr = '0;
    wide_addr[FULL_W-1:0] = full_addr;
    folded = fold_addr(wide_addr, USED_W);
    hit = in_range(folded, LO, HI);
  end
endmodule

// File: rtl/bmd_select.sv
module bmd_select (
  input  logic clk,
  input  logic rw,
  input  logic rom_hit,
  input  logic io_hit,
  output logic ram_cs_n,
  output logic rom_cs_n,
  output logic io_cs_n,
  output logic we_n,
  output logic oe_n
);
  // ROM answers reads only; RAM takes whatever ROM and I/O leave
  assign rom_cs_n = ~(rom_hit & rw);
  assign io_cs_n  = ~io_hit;
  assign ram_cs_n = ~(rom_cs_n & io_cs_n);
  // Strobes live in the high phase only
  assign we_n = ~(clk & ~rw);
  assign oe_n = ~(clk & rw);
endmodule

// File: rtl/banked_mem_decoder.sv
module banked_mem_decoder #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned USED_W = 19,
  parameter logic [23:0] ROM_LO = bmd_pkg::ROM_LO_DEF,
  parameter logic [23:0] ROM_HI = bmd_pkg::ROM_HI_DEF,
  parameter logic [23:0] IO_LO  = bmd_pkg::IO_LO_DEF,
  parameter logic [23:0] IO_HI  = bmd_pkg::IO_HI_DEF
) (
  input  logic              clk,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BANK_W-1:0] data_in,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              io_cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [BANK_W-1:0] bank_q
);
  localparam int unsigned FULL_W = ADDR_W + BANK_W;

  logic [FULL_W-1:0] full_addr;
  logic              rom_hit;
  logic              io_hit;

  bmd_bank_latch #(.WIDTH(BANK_W)) u_latch (
    .clk (clk),
    .d   (data_in),
    .q   (bank_q)
  );

  assign full_addr = {bank_q, addr_in};

  bmd_window #(.FULL_W(FULL_W), .USED_W(USED_W), .LO(ROM_LO), .HI(ROM_HI)) u_rom_win (
    .full_addr (full_addr),
    .hit       (rom_hit)
  );

  bmd_window #(.FULL_W(FULL_W), .USED_W(USED_W), .LO(IO_LO), .HI(IO_HI)) u_io_win (
    .full_addr (full_addr),
    .hit       (io_hit)
  );

  bmd_select u_sel (
    .clk      (clk),
    .rw       (rw),
    .rom_hit  (rom_hit),
    .io_hit   (io_hit),
    .ram_cs_n (ram_cs_n),
    .rom_cs_n (rom_cs_n),
    .io_cs_n  (io_cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n)
  );
endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter int unsigned BANK_W = 8
) (
  input logic              clk,
  input logic              rw,
  input logic [BANK_W-1:0] data_in,
  input logic [BANK_W-1:0] bank_q,
  input logic              rom_hit,
  input logic              io_hit,
  input logic              ram_cs_n,
  input logic              rom_cs_n,
  input logic              io_cs_n,
  input logic              we_n,
  input logic              oe_n
);
  // Becomes 1 after the first low phase has filled the latch
  logic armed_q = 1'b0;
  always_ff @(negedge clk) armed_q <= 1'b1;

  assert_latch_follows_R1: assert property (@(posedge clk) disable iff (!armed_q)
    bank_q == data_in);
  assert_rom_on_read_R2: assert property (@(posedge clk) disable iff (!armed_q)
    (rom_hit && rw) |-> !rom_cs_n);
  assert_rom_no_write_R3: assert property (@(posedge clk) disable iff (!armed_q)
    !rom_cs_n |-> rw);
  assert_io_window_R4: assert property (@(posedge clk) disable iff (!armed_q)
    io_hit |-> !io_cs_n);
  assert_ram_default_R5: assert property (@(posedge clk) disable iff (!armed_q)
    (!rom_hit && !io_hit) |-> !ram_cs_n);
  assert_one_select_R6: assert property (@(posedge clk) disable iff (!armed_q)
    $countones({~ram_cs_n, ~rom_cs_n, ~io_cs_n}) == 1);
  assert_write_strobe_R7: assert property (@(negedge clk) disable iff (!armed_q)
    !rw |-> (!we_n && oe_n));
  assert_read_strobe_R8: assert property (@(negedge clk) disable iff (!armed_q)
    rw |-> (!oe_n && we_n));
  assert_low_phase_idle_R7: assert property (@(posedge clk) disable iff (!armed_q)
    we_n && oe_n); // also covers R8
endmodule

bind banked_mem_decoder bmd_checker #(.BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rw       (rw),
  .data_in  (data_in),
  .bank_q   (bank_q),
  .rom_hit  (rom_hit),
  .io_hit   (io_hit),
  .ram_cs_n (ram_cs_n),
  .rom_cs_n (rom_cs_n),
  .io_cs_n  (io_cs_n),
  .we_n     (we_n),
  .oe_n     (oe_n)
);

// File: tb/banked_mem_decoder_tb.sv
module banked_mem_decoder_tb;
  logic        clk = 1'b0;
  logic        rw = 1'b1;
  logic [15:0] addr_in = '0;
  logic [7:0]  data_in = '0;
  logic        ram_cs_n, rom_cs_n, io_cs_n, we_n, oe_n;
  logic [7:0]  bank_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  banked_mem_decoder u_dut (
    .clk(clk), .rw(rw), .addr_in(addr_in), .data_in(data_in),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
    .we_n(we_n), .oe_n(oe_n), .bank_q(bank_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (bank=%h addr=%h rw=%b)", req, act, exp,
               bank_q, addr_in, rw);
    end
  endtask

  // Expected {ram_n, rom_n, io_n} from the map, restated as page arithmetic
  function automatic logic [2:0] exp_sel(input logic [7:0] b, input logic [15:0] a, input bit rd);
    int unsigned page;
    bit rom, io;
    page = (int'(b & 8'h07) * 256) + int'(a[15:8]); // page index in 512 KiB
    io  = (page == 512);
    rom = rd && (page >= 255) && (page <= 511);
    return {~(~rom & ~io), ~rom, ~io};
  endfunction

  task automatic access(input logic [7:0] b, input logic [15:0] a, input bit rd, input string req);
    logic [2:0] e;
    logic [2:0] got;
    @(negedge clk);
    data_in = b; addr_in = a; rw = rd;
    #5;
    chk(we_n && oe_n, "R7/R8 low phase idle", {30'd0, we_n, oe_n}, 32'd3);
    chk(bank_q == b, "R1 transparent", bank_q, b);
    @(posedge clk);
    #2 data_in = ~b;
    #3;
    chk(bank_q == b, "R1 hold", bank_q, b);
    e = exp_sel(b, a, rd);
    got = {ram_cs_n, rom_cs_n, io_cs_n};
    chk(got == e, req, got, e);
    chk($countones(~got) == 1, "R6 one select", got, e);
    if (rd) chk(!oe_n && we_n, "R8 read strobe", {30'd0, we_n, oe_n}, 32'd2);
    else    chk(!we_n && oe_n, "R7 write strobe", {30'd0, we_n, oe_n}, 32'd1);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    chk(we_n && oe_n, "R7 initial strobes idle", {30'd0, we_n, oe_n}, 32'd3);
    // Full page sweep: R2 R3 R4 R5
    for (int b = 0; b < 8; b++)
      for (int p = 0; p < 256; p++)
        for (int o = 0; o < 2; o++)
          for (int r = 0; r < 2; r++)
            access(8'(b), {8'(p), (o != 0) ? 8'hFF : 8'h00}, r[0], "R2 R3 R4 R5 map");
    // Upper bank bits ignored: R9
    for (int k = 1; k < 32; k++)
      for (int b = 0; b < 8; b++)
        for (int pi = 0; pi < 4; pi++)
          for (int o = 0; o < 2; o++)
            for (int r = 0; r < 2; r++) begin
              logic [7:0] pg;
              pg = (pi == 0) ? 8'h00 : (pi == 1) ? 8'h01 : (pi == 2) ? 8'hFE : 8'hFF;
              access({5'(k), 3'(b)}, {pg, (o != 0) ? 8'hFF : 8'h00}, r[0], "R9 alias");
            end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule